// File: doc/BRIEF.md
# Variable-Length VLIW Bundle Fetch and Unpack Stage

This block feeds an arithmetic pipeline from a clause of packed VLIW bundles. A clause is a run of consecutive 64-bit instruction-memory words, given by a first and a final word address. The block reads these words one per cycle into a circular byte queue, with no notion of where one bundle ends and the next begins. At the head of the queue a decoder locates the bundle boundary, waits until the whole bundle is present, and moves it into a single-entry output register. A downstream stage takes the register with a valid/ready handshake.

A bundle is one to five 8-byte operation slots followed by zero to four 4-byte literals, at most 56 bytes in all. Bit 63 of a slot marks the last slot of the bundle. A three-bit field in the first slot gives the literal count. The output register carries the slots, the literals, both counts and a flag on the final bundle of each clause. A new clause is accepted as soon as the last word of the current one has been requested, so bundles of two clauses can share the queue. Instruction memory answers every read after a fixed latency `LAT`. `QBYTES` must be a power of two and at least 56.

Top module: `vliw_bundle_unpacker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `clause_ready` is 1 and `imem_req` and `bnd_valid` are 0.
- R2: An accepted clause is read as word addresses `clause_first`, `clause_first`+1, ..., `clause_final` (inclusive), in that order, at most one request per cycle, with no gaps in the address sequence.
- R3: A read is requested only when the queue, counting words already in flight, has at least 8 free bytes. The queue never overflows, and when the consumer stalls, requests stop.
- R4: The data word is sampled from `imem_rdata` `LAT` cycles after its request. Bits [31:0] enter the queue before bits [63:32], so a slot keeps its 64-bit value.
- R5: The slot count is the position of the first slot whose bit 63 is 1. If none of five slots has it set, the bundle has five slots.
- R6: Bits [58:56] of the first slot give the literal count, saturating at 4 for the values 5 to 7. Literal i is the i-th 32-bit word after the last slot and appears at `bnd_lits[32*i +: 32]`.
- R7: A bundle is moved into the output register only when all of its 2*slots+literals words are in the queue.
- R8: While `bnd_valid` is 1 and `bnd_ready` is 0, every output field holds its value. Slot and literal fields beyond the counts are zero.
- R9: `bnd_last` is 1 exactly on the bundle that holds the final word of its clause. Each clause contains whole bundles and an even number of 4-byte words.
- R10: The cycle after the request for `clause_final`, `clause_ready` is 1 and the next clause may be accepted while bundles of the earlier one are still queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clause_valid | input | 1 | Clause descriptor offered |
| clause_ready | output | 1 | Fetch idle, descriptor accepted when valid |
| clause_first | input | AW | First word address of the clause |
| clause_final | input | AW | Final word address of the clause, inclusive |
| imem_req | output | 1 | Instruction-memory read request |
| imem_addr | output | AW | Word address of the read |
| imem_rdata | input | 64 | Read data, LAT cycles after the request |
| bnd_valid | output | 1 | Decoded bundle held in the output register |
| bnd_ready | input | 1 | Downstream takes the bundle |
| bnd_slots | output | 320 | Slot k at bits [64*k +: 64] |
| bnd_lits | output | 128 | Literal i at bits [32*i +: 32] |
| bnd_nslots | output | 3 | Slot count, 1 to 5 |
| bnd_nlits | output | 3 | Literal count, 0 to 4 |
| bnd_last | output | 1 | Final bundle of its clause |

## Verification
The stimulus mixes odd literal counts, so bundles start on 4-byte positions that do not line up with fetch words. A design that assumed word alignment would mix slot and literal halves. One bundle has no stop bit in any of its five slots, and one carries a literal field of 7. A decoder without the slot cap would run into the next bundle, and one without saturation would swallow extra words. A long consumer stall fills the queue, which catches a credit that ignores in-flight reads by producing overwritten bundles or a runaway request count. Clauses placed back to back and with address gaps show a late `clause_ready`, a misplaced last flag, or a lost word at a clause seam.

// File: rtl/vliw_bundle_unpacker.sv
module vliw_bundle_unpacker #(
  parameter int AW     = 16,
  parameter int QBYTES = 64,
  parameter int LAT    = 2
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clause_valid,
  output logic          clause_ready,
  input  logic [AW-1:0] clause_first,
  input  logic [AW-1:0] clause_final,
  output logic          imem_req,
  output logic [AW-1:0] imem_addr,
  input  logic [63:0]   imem_rdata,
  output logic          bnd_valid,
  input  logic          bnd_ready,
  output logic [319:0]  bnd_slots,
  output logic [127:0]  bnd_lits,
  output logic [2:0]    bnd_nslots,
  output logic [2:0]    bnd_nlits,
  output logic          bnd_last
);
  localparam int QW = QBYTES / 4;
  localparam int PW = $clog2(QW);
  localparam int CW = $clog2(QW + 1) + 1;

  logic          busy;
  logic [AW-1:0] cur, fin;
  logic [LAT-1:0] pv, pt;
  logic [CW-1:0] pend, occ;
  logic [31:0]   qd [QW];
  logic [QW-1:0] qe;
  logic [PW-1:0] head, tail;

  logic [2:0]  ns, nl;
  logic        ns_ok, blk, complete, take, last_w;
  logic [3:0]  len;
  logic [63:0] slot_w [5];
  logic [31:0] lit_w [4];

  wire          acc      = clause_valid && !busy;
  wire [CW:0]   used     = {1'b0, occ} + {pend, 1'b0};
  wire          issue    = busy && ((used + (CW+1)'(2)) <= (CW+1)'(QW));
  wire          arrive   = pv[LAT-1];
  wire          arr_last = pt[LAT-1];

  assign clause_ready = !busy;
  assign imem_req     = issue;
  assign imem_addr    = cur;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      cur  <= '0;
      fin  <= '0;
    end else if (acc) begin
      busy <= 1'b1;
      cur  <= clause_first;
      fin  <= clause_final;
    end else if (issue) begin
      cur <= cur + 1'b1;
      if (cur == fin) busy <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pv   <= '0;
      pt   <= '0;
      pend <= '0;
    end else begin
      pv[0] <= issue;
      pt[0] <= issue && (cur == fin);
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1];
        pt[i] <= pt[i-1];
      end
      pend <= pend + CW'(issue) - CW'(arrive);
    end

  always_comb begin
    ns_ok = 1'b0;
    blk   = 1'b0;
    ns    = 3'd5;
    for (int k = 0; k < 5; k++) begin
      if (!ns_ok && !blk) begin
        if (occ < CW'(2*k + 2)) blk = 1'b1;
        else if (qd[head + PW'(2*k + 1)][31] || k == 4) begin
          ns_ok = 1'b1;
          ns    = 3'(k + 1);
        end
      end
    end
    nl = (qd[head + PW'(1)][26:24] > 3'd4) ? 3'd4 : qd[head + PW'(1)][26:24];
    len = {ns, 1'b0} + {1'b0, nl};
    complete = ns_ok && (occ >= CW'(len));
    for (int k = 0; k < 5; k++)
      slot_w[k] = (3'(k) < ns) ? {qd[head + PW'(2*k + 1)], qd[head + PW'(2*k)]} : 64'd0;
    for (int i = 0; i < 4; i++)
      lit_w[i] = (3'(i) < nl) ? qd[head + PW'({ns, 1'b0}) + PW'(i)] : 32'd0;
    last_w = qe[head + PW'(len) - PW'(1)];
  end

  assign take = complete && (!bnd_valid || bnd_ready);

  always_ff @(posedge clk)
    if (arrive) begin
      qd[tail]          <= imem_rdata[31:0];
      qd[tail + PW'(1)] <= imem_rdata[63:32];
      qe[tail]          <= 1'b0;
      qe[tail + PW'(1)] <= arr_last;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      if (arrive) tail <= tail + PW'(2);
      if (take)   head <= head + PW'(len);
      occ <= occ + (arrive ? CW'(2) : CW'(0)) - (take ? CW'(len) : CW'(0));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bnd_valid  <= 1'b0;
      bnd_slots  <= '0;
      bnd_lits   <= '0;
      bnd_nslots <= '0;
      bnd_nlits  <= '0;
      bnd_last   <= 1'b0;
    end else if (take) begin
      bnd_valid  <= 1'b1;
      bnd_slots  <= {slot_w[4], slot_w[3], slot_w[2], slot_w[1], slot_w[0]};
      bnd_lits   <= {lit_w[3], lit_w[2], lit_w[1], lit_w[0]};
      bnd_nslots <= ns;
      bnd_nlits  <= nl;
      bnd_last   <= last_w;
    end else if (bnd_ready) begin
      bnd_valid <= 1'b0;
    end
endmodule

module vliw_bundle_unpacker_chk #(
  parameter int AW = 16,
  parameter int QW = 16,
  parameter int CW = 6
)(
  input logic          clk,
  input logic          rst_n,
  input logic          imem_req,
  input logic [AW-1:0] imem_addr,
  input logic [CW-1:0] occ,
  input logic [CW-1:0] pend,
  input logic          bnd_valid,
  input logic          bnd_ready,
  input logic [319:0]  bnd_slots,
  input logic [127:0]  bnd_lits,
  input logic [2:0]    bnd_nslots,
  input logic [2:0]    bnd_nlits,
  input logic          bnd_last
);
  p_credit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req |-> (int'(occ) + 2*int'(pend) + 2 <= QW));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) + 2*int'(pend) <= QW);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req && $past(imem_req) |-> imem_addr == $past(imem_addr) + 1'b1);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_valid && !bnd_ready |=> bnd_valid && $stable(bnd_slots) && $stable(bnd_lits)
      && $stable(bnd_nslots) && $stable(bnd_nlits) && $stable(bnd_last));

  p_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_valid |-> bnd_nslots >= 3'd1 && bnd_nslots <= 3'd5 && bnd_nlits <= 3'd4);

  p_stop_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_valid && bnd_nslots >= 3'd1 && bnd_nslots < 3'd5 |-> bnd_slots[64*int'(bnd_nslots) - 1]);

  p_zero_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_valid |-> ((bnd_slots >> (64*int'(bnd_nslots))) == '0)
      && ((bnd_lits >> (32*int'(bnd_nlits))) == '0));
endmodule

bind vliw_bundle_unpacker vliw_bundle_unpacker_chk #(.AW(AW), .QW(QW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .imem_req(imem_req), .imem_addr(imem_addr),
  .occ(occ), .pend(pend), .bnd_valid(bnd_valid), .bnd_ready(bnd_ready),
  .bnd_slots(bnd_slots), .bnd_lits(bnd_lits), .bnd_nslots(bnd_nslots),
  .bnd_nlits(bnd_nlits), .bnd_last(bnd_last)
);

// File: tb/sim_vliw_bundle_unpacker.sv
module sim_vliw_bundle_unpacker;
  localparam int AW = 16, QB = 64, LAT = 2, QW = QB / 4, NC = 6, MAXB = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic clause_valid = 1'b0, clause_ready;
  logic [AW-1:0] clause_first = '0, clause_final = '0;
  logic imem_req; logic [AW-1:0] imem_addr; logic [63:0] imem_rdata;
  logic bnd_valid, bnd_ready = 1'b0, bnd_last;
  logic [319:0] bnd_slots; logic [127:0] bnd_lits;
  logic [2:0] bnd_nslots, bnd_nlits;

  vliw_bundle_unpacker #(.AW(AW), .QBYTES(QB), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .clause_valid(clause_valid), .clause_ready(clause_ready),
    .clause_first(clause_first), .clause_final(clause_final), .imem_req(imem_req),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata), .bnd_valid(bnd_valid),
    .bnd_ready(bnd_ready), .bnd_slots(bnd_slots), .bnd_lits(bnd_lits),
    .bnd_nslots(bnd_nslots), .bnd_nlits(bnd_nlits), .bnd_last(bnd_last));

  int checks = 0, fails = 0;
  logic [63:0] mem [0:511];
  int e_ns [MAXB], e_nl [MAXB];
  logic [63:0] e_slot [MAXB][5];
  logic [31:0] e_lit [MAXB][4];
  bit e_last [MAXB];
  int nb = 0;
  int c_first [NC], c_final [NC];
  logic [31:0] seed = 32'h1234_5677;
  logic [31:0] wq [$];

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic add_bundle(input int ns, input int field, input bit stop, input bit last);
    logic [63:0] v; logic [31:0] l; int nl;
    for (int k = 0; k < 5; k++) begin
      if (k < ns) begin
        v = {rnd(), rnd()};
        v[63] = stop && (k == ns - 1);
        if (k == 0) v[58:56] = field[2:0];
        e_slot[nb][k] = v;
        wq.push_back(v[31:0]); wq.push_back(v[63:32]);
      end else e_slot[nb][k] = 64'd0;
    end
    nl = (field > 4) ? 4 : field;
    for (int i = 0; i < 4; i++) begin
      if (i < nl) begin l = rnd(); e_lit[nb][i] = l; wq.push_back(l); end
      else e_lit[nb][i] = 32'd0;
    end
    e_ns[nb] = ns; e_nl[nb] = nl; e_last[nb] = last; nb++;
  endtask

  task automatic build();
    int addr, nbund, ns, field;
    for (int j = 0; j < 512; j++) mem[j] = 64'd0;
    addr = 3;
    for (int c = 0; c < NC; c++) begin
      c_first[c] = addr; wq.delete();
      nbund = 6 + (c % 3);
      for (int b = 0; b < nbund; b++) begin
        ns = 1 + int'(rnd() % 5);
        if (b == nbund - 1) begin
          if (wq.size() % 2 == 1) field = (rnd() % 2 == 0) ? 1 : 3;
          else field = 2 * int'(rnd() % 3);
          add_bundle(ns, field, 1'b1, 1'b1);
        end else if (c == 0 && b == 1) add_bundle(5, 2, 1'b0, 1'b0);
        else if (c == 0 && b == 2) add_bundle(ns, 7, 1'b1, 1'b0);
        else add_bundle(ns, int'(rnd() % 8), 1'b1, 1'b0);
      end
      for (int j = 0; j < wq.size() / 2; j++) mem[addr + j] = {wq[2*j + 1], wq[2*j]};
      c_final[c] = addr + wq.size() / 2 - 1;
      addr = c_final[c] + 1 + (c % 2);
    end
  endtask

  // memory model: fixed latency, request captured away from the edge
  logic req_q = 1'b0; int addr_q = 0;
  logic [LAT-1:0] mv = '0; int ma [LAT];
  always @(posedge clk) begin
    mv[0] <= req_q; ma[0] <= addr_q;
    for (int i = 1; i < LAT; i++) begin mv[i] <= mv[i-1]; ma[i] <= ma[i-1]; end
  end
  assign imem_rdata = mv[LAT-1] ? mem[ma[LAT-1]] : 64'd0;
  int words_arr = 0;
  always @(posedge clk) if (mv[LAT-1]) words_arr <= words_arr + 2;

  // reference monitor, compared every clock
  bit running = 0, chk_rdy = 0, prev_stall = 0;
  int rmode = 0, ac = 0, exp_addr = 0, got = 0, words_out = 0, words_in = 0;
  logic [319:0] s_slots; logic [127:0] s_lits; logic [2:0] s_ns, s_nl; logic s_last;

  always @(negedge clk) begin
    logic r;
    req_q = imem_req; addr_q = int'(imem_addr);
    if (running) begin
      if (chk_rdy) begin
        chk(clause_ready, "R10", "clause_ready after final address", 64'(clause_ready), 64'd1);
        chk_rdy = 0;
      end
      if (imem_req) begin
        chk(ac < NC && imem_addr == AW'(exp_addr), "R2", "fetch address", 64'(imem_addr), 64'(exp_addr));
        words_out += 2;
        if (ac < NC && exp_addr == c_final[ac]) begin
          chk_rdy = 1; ac++;
          exp_addr = (ac < NC) ? c_first[ac] : 0;
        end else exp_addr++;
      end
      if (prev_stall)
        chk(bnd_valid && bnd_slots == s_slots && bnd_lits == s_lits && bnd_nslots == s_ns
            && bnd_nlits == s_nl && bnd_last == s_last, "R8", "held bundle", 64'(bnd_valid), 64'd1);
      case (rmode)
        0: r = 1'b1;
        1: r = rnd()[3];
        default: r = 1'b0;
      endcase
      bnd_ready = r;
      if (bnd_valid && r) begin
        if (got >= nb) chk(0, "R9", "extra bundle", 64'(got), 64'(nb));
        else begin
          chk(int'(bnd_nslots) == e_ns[got], "R5", "slot count", 64'(bnd_nslots), 64'(e_ns[got]));
          chk(int'(bnd_nlits) == e_nl[got], "R6", "literal count", 64'(bnd_nlits), 64'(e_nl[got]));
          for (int k = 0; k < 5; k++)
            chk(bnd_slots[64*k +: 64] == e_slot[got][k], (k < e_ns[got]) ? "R4" : "R8",
                $sformatf("bundle %0d slot %0d", got, k), bnd_slots[64*k +: 64], e_slot[got][k]);
          for (int i = 0; i < 4; i++)
            chk(bnd_lits[32*i +: 32] == e_lit[got][i], (i < e_nl[got]) ? "R6" : "R8",
                $sformatf("bundle %0d literal %0d", got, i), 64'(bnd_lits[32*i +: 32]), 64'(e_lit[got][i]));
          chk(bnd_last == e_last[got], "R9", $sformatf("bundle %0d last flag", got),
              64'(bnd_last), 64'(e_last[got]));
          words_in += 2 * e_ns[got] + e_nl[got];
          chk(words_arr >= words_in, "R7", "bundle words present", 64'(words_arr), 64'(words_in));
          got++;
        end
      end
      prev_stall = bnd_valid && !r;
      s_slots = bnd_slots; s_lits = bnd_lits; s_ns = bnd_nslots; s_nl = bnd_nlits; s_last = bnd_last;
      chk(words_out - words_in <= QW + 14, "R3", "words outstanding", 64'(words_out - words_in), 64'(QW + 14));
    end
  end

  initial begin
    int cyc;
    build();
    exp_addr = c_first[0];
    repeat (3) @(negedge clk);
    chk(clause_ready == 1'b1, "R1", "clause_ready in reset", 64'(clause_ready), 64'd1);
    chk(imem_req == 1'b0, "R1", "imem_req in reset", 64'(imem_req), 64'd0);
    chk(bnd_valid == 1'b0, "R1", "bnd_valid in reset", 64'(bnd_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(clause_ready && !imem_req && !bnd_valid, "R1", "state after reset", 64'(clause_ready), 64'd1);
    rmode = 1; running = 1;
    fork
      begin
        for (int c = 0; c < NC; c++) begin
          @(negedge clk);
          clause_valid = 1'b1; clause_first = AW'(c_first[c]); clause_final = AW'(c_final[c]);
          while (!clause_ready) @(negedge clk);
        end
        @(negedge clk);
        clause_valid = 1'b0;
      end
    join_none
    repeat (60) @(negedge clk);
    rmode = 2;
    repeat (100) @(negedge clk);
    chk(imem_req == 1'b0, "R3", "fetch stopped under stall", 64'(imem_req), 64'd0);
    chk(bnd_valid == 1'b1, "R8", "bundle waiting under stall", 64'(bnd_valid), 64'd1);
    rmode = 0;
    cyc = 0;
    while (got < nb && cyc < 20000) begin @(negedge clk); cyc++; end
    if (got < nb) chk(0, "R2", "watchdog expired", 64'(got), 64'(nb));
    repeat (20) @(negedge clk);
    chk(ac == NC, "R2", "all clauses fetched", 64'(ac), 64'(NC));
    chk(!bnd_valid && !imem_req && clause_ready, "R10", "idle at end", 64'(bnd_valid), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule